// File: doc/BRIEF.md
# Configuration Bank Bit Loader

This block takes over the byte stream once a parser has decoded a command that writes one of the configuration or block-memory banks. When `start` is pulsed it captures the bank geometry (column count, row count and starting row) together with the bank number and whether the target is a configuration bank or a block-memory bank. It then pulls data bytes through a valid/ready handshake and turns each one into single-bit writes. Every write carries a bank select, a column, a row and the bit value. Bits leave each byte most significant first. The column advances fastest, and the row advances when the column wraps at the bank width.

After the last data bit the loader expects two trailer bytes, both of value zero. When the second trailer byte is taken it raises `done` for one cycle. `frame_err` is high alongside `done` if either trailer byte was nonzero. The loader then returns to idle, and the parser takes back the byte stream.

The controller has six states. LD_IDLE waits for `start`. LD_FETCH holds `byte_ready` high until a data byte arrives. LD_SHIFT emits one bit per cycle. LD_TRAIL0 and LD_TRAIL1 take the two trailer bytes. LD_FINISH gives the completion pulse. The transitions are:

- IDLE→FETCH on `start` with a nonzero area.
- IDLE→TRAIL0 on `start` with zero area.
- FETCH→SHIFT when a byte is accepted.
- SHIFT→FETCH after the eighth bit of a byte when bits remain.
- SHIFT→TRAIL0 after the last bit of the block.
- TRAIL0→TRAIL1 and TRAIL1→FINISH on each accepted byte.
- FINISH→IDLE unconditionally.

Top module: `cfg_bank_loader`

## Requirements
- R1: After `start`, the loader accepts exactly ceil(width×height/8) data bytes and then exactly two trailer bytes, and no more.
- R2: Data bit number i of the block (counting from bit 7 of the first byte downward, then on through the following bytes) is written to column i mod width and row offset + i div width.
- R3: `wr_bank` equals {is_bram, bank_num} as captured at `start`, so bit 2 set means a block-memory bank and bits 1:0 give the bank number.
- R4: At most one bit write is issued per cycle. `byte_ready` is low in every cycle in which `wr_strobe` is high. The 8 bits of a full data byte are issued on 8 consecutive cycles.
- R5: When width×height is not a multiple of 8, the unused low bits of the final data byte produce no write strobe.
- R6: `frame_err` is high during the `done` cycle exactly when at least one of the two trailer bytes was nonzero, and it is low in all other cycles.
- R7: `done` is a single-cycle pulse, issued in the cycle after the second trailer byte is accepted. Afterwards `byte_ready` stays low until the next `start`.
- R8: With a zero width or zero height, no data byte is taken and no write is issued. The loader goes straight to the trailer check.
- R9: After reset `byte_ready`, `wr_strobe`, `done` and `frame_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that begins a bank load; sampled only in idle |
| is_bram | input | 1 | Target kind: 1 = block-memory bank, 0 = configuration bank |
| bank_num | input | BANK_W | Bank number within the kind |
| bank_width | input | DIM_W | Columns per row |
| bank_height | input | DIM_W | Rows in this chunk |
| bank_offset | input | DIM_W | First row written |
| byte_valid | input | 1 | Incoming byte present |
| byte_data | input | 8 | Incoming byte |
| byte_ready | output | 1 | Loader takes the byte this cycle |
| wr_strobe | output | 1 | One bit write this cycle |
| wr_bank | output | BANK_W+1 | Bank select {kind, number} |
| wr_col | output | DIM_W | Column of the bit |
| wr_row | output | DIM_W | Row of the bit |
| wr_bit | output | 1 | Bit value |
| done | output | 1 | Load complete pulse |
| frame_err | output | 1 | Trailer was not two zero bytes; valid with done |

## Verification
The bench aims at the column wrap for widths of 1 and of non-powers of two. A design that wrapped one column late or failed to step the row would send bits to the wrong coordinates. A 15-bit block checks that the surplus bit of the final byte is dropped. A design that emitted it would push one write too many, and one that counted bytes wrongly would hang waiting for a trailer. The bench also tries a nonzero first trailer byte, a nonzero second trailer byte, an empty bank and irregular gaps between bytes. These show whether the error flag is tracked across both trailer bytes and whether back-pressure holds while a byte is being unpacked.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
    typedef enum logic [2:0] {
        LD_IDLE,
        LD_FETCH,
        LD_SHIFT,
        LD_TRAIL0,
        LD_TRAIL1,
        LD_FINISH
    } ld_state_t;
endpackage

// File: rtl/cbl_coord_gen.sv
module cbl_coord_gen #(
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [DIM_W-1:0] width_in,
    input  logic [DIM_W-1:0] offset_in,
    output logic [DIM_W-1:0] col,
    output logic [DIM_W-1:0] row
);
    logic [DIM_W-1:0] width_q;
    logic             at_edge;

    assign at_edge = (col == width_q - DIM_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
            col     <= '0;
            row     <= '0;
        end else if (load) begin
            width_q <= width_in;
            col     <= '0;
            row     <= offset_in;
        end else if (advance) begin
            if (at_edge) begin
                col <= '0;
                row <= row + DIM_W'(1);
            end else begin
                col <= col + DIM_W'(1);
            end
        end
    end

    // R2
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && at_edge) |=> (col == '0 && row == $past(row) + DIM_W'(1)));

    // R2
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && !at_edge) |=> (col == $past(col) + DIM_W'(1) && $stable(row)));
endmodule

// File: rtl/cbl_bit_shifter.sv
module cbl_bit_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] din,
    output logic              msb,
    output logic              last_bit
);
    localparam int IDX_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sreg;
    logic [IDX_W-1:0]  left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            left <= '0;
        end else if (load) begin
            sreg <= din;
            left <= IDX_W'(BYTE_W - 1);
        end else if (shift) begin
            sreg <= {sreg[BYTE_W-2:0], 1'b0};
            left <= left - IDX_W'(1);
        end
    end

    assign msb      = sreg[BYTE_W-1];
    assign last_bit = (left == '0);

    // R2
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (msb == $past(din[BYTE_W-1])));
endmodule

// File: rtl/cfg_bank_loader.sv
module cfg_bank_loader
    import cbl_pkg::*;
#(
    parameter int DIM_W  = 16,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_bram,
    input  logic [BANK_W-1:0] bank_num,
    input  logic [DIM_W-1:0]  bank_width,
    input  logic [DIM_W-1:0]  bank_height,
    input  logic [DIM_W-1:0]  bank_offset,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              wr_strobe,
    output logic [BANK_W:0]   wr_bank,
    output logic [DIM_W-1:0]  wr_col,
    output logic [DIM_W-1:0]  wr_row,
    output logic              wr_bit,
    output logic              done,
    output logic              frame_err
);
    localparam int CNT_W = 2 * DIM_W;

    ld_state_t        state, state_nx;
    logic [CNT_W-1:0] bits_left;
    logic [CNT_W-1:0] area;
    logic [BANK_W:0]  bank_q;
    logic             err_q;
    logic             begin_load, take_byte, sh_load, sh_shift, sh_msb, sh_last;

    assign area       = CNT_W'(bank_width) * CNT_W'(bank_height);
    assign begin_load = (state == LD_IDLE) && start;
    assign take_byte  = byte_ready && byte_valid;
    assign sh_load    = (state == LD_FETCH) && byte_valid;
    assign sh_shift   = (state == LD_SHIFT);

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE:   if (start) state_nx = (area == '0) ? LD_TRAIL0 : LD_FETCH;
            LD_FETCH:  if (byte_valid) state_nx = LD_SHIFT;
            LD_SHIFT: begin
                if (bits_left == CNT_W'(1)) state_nx = LD_TRAIL0;
                else if (sh_last)           state_nx = LD_FETCH;
            end
            LD_TRAIL0: if (byte_valid) state_nx = LD_TRAIL1;
            LD_TRAIL1: if (byte_valid) state_nx = LD_FINISH;
            LD_FINISH: state_nx = LD_IDLE;
            default:   state_nx = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_left <= '0;
            bank_q    <= '0;
            err_q     <= 1'b0;
        end else begin
            if (begin_load) begin
                bits_left <= area;
                bank_q    <= {is_bram, bank_num};
                err_q     <= 1'b0;
            end else if (sh_shift) begin
                bits_left <= bits_left - CNT_W'(1);
            end
            if (take_byte && (state == LD_TRAIL0 || state == LD_TRAIL1) && byte_data != 8'h00)
                err_q <= 1'b1;
        end
    end

    always_comb begin
        byte_ready = 1'b0;
        wr_strobe  = 1'b0;
        done       = 1'b0;
        frame_err  = 1'b0;
        unique case (state)
            LD_IDLE:   ;
            LD_FETCH:  byte_ready = 1'b1;
            LD_SHIFT:  wr_strobe  = 1'b1;
            LD_TRAIL0: byte_ready = 1'b1;
            LD_TRAIL1: byte_ready = 1'b1;
            LD_FINISH: begin
                done      = 1'b1;
                frame_err = err_q;
            end
            default:   ;
        endcase
    end

    assign wr_bank = bank_q;
    assign wr_bit  = sh_msb;

    cbl_bit_shifter #(.BYTE_W(8)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .shift    (sh_shift),
        .din      (byte_data),
        .msb      (sh_msb),
        .last_bit (sh_last)
    );

    cbl_coord_gen #(.DIM_W(DIM_W)) u_coord (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (begin_load),
        .advance   (sh_shift),
        .width_in  (bank_width),
        .offset_in (bank_offset),
        .col       (wr_col),
        .row       (wr_row)
    );

    // R1
    fetch_needs_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LD_FETCH && byte_valid) |-> (bits_left != '0));

    // R4
    strobe_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> !byte_ready);

    // R6
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> done);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !byte_ready));

    // R8
    empty_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (begin_load && area == '0) |=> (state == LD_TRAIL0));
endmodule

// File: tb/cfg_bank_loader_test.sv
module cfg_bank_loader_test;
    localparam int DIM_W  = 16;
    localparam int BANK_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              is_bram = 1'b0;
    logic [BANK_W-1:0] bank_num = '0;
    logic [DIM_W-1:0]  bank_width = '0, bank_height = '0, bank_offset = '0;
    logic              byte_valid = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              byte_ready, wr_strobe, wr_bit, done, frame_err;
    logic [BANK_W:0]   wr_bank;
    logic [DIM_W-1:0]  wr_col, wr_row;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int exp_col[$];
    int exp_row[$];
    int exp_bit[$];
    int exp_bank = 0;
    int strobe_run = 0;

    always #4 clk = ~clk;

    cfg_bank_loader #(.DIM_W(DIM_W), .BANK_W(BANK_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_bram(is_bram),
        .bank_num(bank_num), .bank_width(bank_width), .bank_height(bank_height),
        .bank_offset(bank_offset), .byte_valid(byte_valid), .byte_data(byte_data),
        .byte_ready(byte_ready), .wr_strobe(wr_strobe), .wr_bank(wr_bank),
        .wr_col(wr_col), .wr_row(wr_row), .wr_bit(wr_bit), .done(done),
        .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference comparison on every clock, sampled on the falling edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (wr_strobe) begin
                strobe_run++;
                // R4
                check(!byte_ready, "R4 ready during unpack", int'(byte_ready), 0);
                if (exp_col.size() == 0) begin
                    // R5 / R1: no write may appear beyond the block
                    check(1'b0, "R5 extra write", 1, 0);
                end else begin
                    int c, r, b;
                    c = exp_col.pop_front();
                    r = exp_row.pop_front();
                    b = exp_bit.pop_front();
                    // R2
                    check(int'(wr_col) == c, "R2 column", int'(wr_col), c);
                    check(int'(wr_row) == r, "R2 row", int'(wr_row), r);
                    check(int'(wr_bit) == b, "R2 bit value", int'(wr_bit), b);
                    // R3
                    check(int'(wr_bank) == exp_bank, "R3 bank select", int'(wr_bank), exp_bank);
                end
            end else begin
                // R4: full bytes give 8 back-to-back strobes
                if (strobe_run != 0 && strobe_run % 8 != 0 && exp_col.size() != 0)
                    check(1'b0, "R4 broken strobe run", strobe_run, 8);
                strobe_run = 0;
            end
            if (!done)
                // R6
                if (frame_err) check(1'b0, "R6 error outside done", 1, 0);
        end
    end

    task automatic send_byte(input logic [7:0] b, input int gap);
        for (int g = 0; g < gap; g++) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        while (!byte_ready) @(negedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        byte_data  = 8'h00;
    endtask

    task automatic run_load(input bit bram, input int bank, input int w, input int h,
                            input int off, input logic [7:0] t0, input logic [7:0] t1,
                            input int seed, input int gap, input string tag);
        int total, nbytes, seen_done, wait_cnt;
        logic [7:0] data[$];
        total  = w * h;
        nbytes = (total + 7) / 8;
        for (int k = 0; k < nbytes; k++) data.push_back(8'((seed * 37 + k * 29 + 5) & 255));
        for (int i = 0; i < total; i++) begin
            exp_col.push_back(i % w);
            exp_row.push_back((off + i / w) & 16'hFFFF);
            exp_bit.push_back(int'(data[i / 8][7 - (i % 8)]));
        end
        exp_bank = (int'(bram) << 2) | bank;
        @(negedge clk);
        start = 1'b1; is_bram = bram; bank_num = BANK_W'(bank);
        bank_width = DIM_W'(w); bank_height = DIM_W'(h); bank_offset = DIM_W'(off);
        @(negedge clk);
        start = 1'b0;
        foreach (data[k]) send_byte(data[k], (k % 3 == 1) ? gap : 0);
        // R1: every data bit written before trailer is taken
        send_byte(t0, 0);
        check(exp_col.size() == 0, {"R1 bits pending at trailer ", tag}, exp_col.size(), 0);
        send_byte(t1, gap);
        seen_done = 0;
        wait_cnt  = 0;
        // send_byte returns one negedge after acceptance: done is visible now
        while (!done && wait_cnt < 20) begin
            @(negedge clk);
            wait_cnt++;
        end
        // R7
        check(done && wait_cnt == 0, {"R7 done timing ", tag}, wait_cnt, 0);
        // R6
        check(frame_err == (t0 != 0 || t1 != 0), {"R6 trailer error ", tag},
              int'(frame_err), int'(t0 != 0 || t1 != 0));
        @(negedge clk);
        // R7
        check(!done && !byte_ready, {"R7 idle after done ", tag}, int'(done | byte_ready), 0);
        exp_col.delete(); exp_row.delete(); exp_bit.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9
        check(!byte_ready && !wr_strobe && !done && !frame_err, "R9 reset state",
              int'({byte_ready, wr_strobe, done, frame_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!byte_ready, "R9 idle no ready", int'(byte_ready), 0);
        // R2 R3 basic configuration bank
        run_load(1'b0, 0, 8, 2, 0, 8'h00, 8'h00, 1, 0, "8x2");
        // R5 15 bits, surplus bit dropped, block-memory bank 3
        run_load(1'b1, 3, 5, 3, 10, 8'h00, 8'h00, 2, 2, "5x3");
        // R2 offset and wider bank
        run_load(1'b0, 2, 16, 4, 100, 8'h00, 8'h00, 3, 1, "16x4");
        // R2 width one
        run_load(1'b1, 1, 1, 11, 7, 8'h00, 8'h00, 4, 3, "1x11");
        // R6 first trailer byte bad
        run_load(1'b0, 1, 3, 3, 0, 8'h40, 8'h00, 5, 0, "t0bad");
        // R6 second trailer byte bad
        run_load(1'b1, 0, 6, 2, 2, 8'h00, 8'h01, 6, 1, "t1bad");
        // R8 empty bank
        run_load(1'b0, 3, 0, 5, 0, 8'h00, 8'h00, 7, 0, "empty");
        // R8 empty with bad trailer
        run_load(1'b1, 2, 4, 0, 0, 8'hFF, 8'hFF, 8, 0, "empty-bad");
        // R1 recovery after an error
        run_load(1'b0, 0, 7, 7, 3, 8'h00, 8'h00, 9, 2, "7x7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule